// File: doc/BRIEF.md
# Write-Only Command Receiver on a Two-Wire Serial Bus

This block is a target device on a two-wire serial bus (I2C). It takes in a fixed-length command of three data bytes and hands it to the surrounding logic as a single 24-bit word. The clock line and the data line arrive as raw inputs. Each line is synchronised to the system clock and passes through a glitch filter. Bus-level start and stop events are then derived from the filtered lines. The data line is driven back only through an active-high pull-down enable, which suits an open-drain pad.

The 7-bit device address comes from a 2-bit strap code. The block also answers a fixed broadcast address, so that one transaction can load the same command into every such device on the bus. Reads are refused. A write must carry exactly three data bytes. When the third byte is complete, the word appears with a one-cycle valid pulse. Any later byte is refused. A start or stop in the middle of a transfer throws away whatever has been gathered so far.

Top module: `i2c_cmd_slave`

## Requirements
- R1: While reset is held, and after it is released with an idle bus, `sda_oe` and `cmd_valid` are both 0.
- R2: A START is detected when SDA falls while SCL is high, and it opens address decoding. A STOP is detected when SDA rises while SCL is high, and it returns the block to idle. A byte clocked after a STOP, with no new START, is not acknowledged.
- R3: The device address depends on `strap_i`. Code 2'b00 gives 7'h10, 2'b01 gives 7'h11, and 2'b10 or 2'b11 gives 7'h12. The address byte is seven address bits, most significant bit first, followed by the R/W bit, with 0 meaning write. When a write is addressed to the device, `sda_oe` is 1 throughout the 9th clock.
- R4: A write to the broadcast address 7'h73 is acknowledged for every strap code.
- R5: When the address does not match, the block does not acknowledge it. It also acknowledges no later byte until the next START or STOP, and it gives no valid pulse.
- R6: A read (R/W = 1) is never acknowledged, even to a matching address. The bytes that follow in the same transaction are not acknowledged either.
- R7: `sda_oe` changes only while the filtered SCL is low. During the high period of an acknowledge clock its level is constant.
- R8: After a matching write address, each of the first three data bytes is acknowledged on its 9th clock.
- R9: When the third data byte has been received, `cmd_valid` is 1 for exactly one cycle. At that point `cmd_word` holds the first byte in bits 23:16, the second in 15:8 and the third in 7:0.
- R10: Any data byte after the third in the same transaction is not acknowledged and produces no further valid pulse.
- R11: A START or STOP before the third byte completes discards the partial word and gives no valid pulse. A repeated START begins a new address phase, and only the bytes after that START form the word.
- R12: A pulse on SCL that lasts fewer than `FILT_LEN` system clocks is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wired bus |
| strap_i | input | 2 | Address strap code: 00 low, 01 float, 10 high, 11 treated as high |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_valid | output | 1 | One-cycle strobe: a complete command word is present |
| cmd_word | output | 24 | Received command, first byte in the most significant position |

## Verification
The hardest situations to produce are the ones where the transaction stops looking like a clean three-byte write. Examples are a repeated START that lands after one data byte has already been acknowledged, and a fourth byte that follows a valid strobe. The bench reaches these by building every transaction from start, byte and stop primitives and running them against a wired-AND model of the data line. It compares the acknowledge it reads back on the bus, and the count of valid strobes, with values worked out from the address rules. The acknowledge level is sampled twice in each high period, so a change while SCL is high is also caught.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_DATA   = 2'd2,
    PH_IGNORE = 2'd3
  } phase_t;

  // Strap code to device address: low, float, high (code 3 acts as high).
  function automatic logic [6:0] strap_addr(input logic [1:0] code,
                                            input logic [6:0] base);
    case (code)
      2'b00:   strap_addr = base;
      2'b01:   strap_addr = base + 7'd1;
      default: strap_addr = base + 7'd2;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [6:0] addr,
                                    input logic [6:0] own,
                                    input logic [6:0] bcast);
    addr_hit = (addr == own) || (addr == bcast);
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       dev_cnt;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      dev_cnt <= '0;
      line_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sync_out == line_o) begin
        dev_cnt <= '0;
      end else if (dev_cnt == CNT_W'(FILT_LEN - 1)) begin
        line_o  <= sync_out;
        dev_cnt <= '0;
      end else begin
        dev_cnt <= dev_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int         DATA_BYTES = 3,
  parameter logic [6:0] BASE_ADDR  = 7'h10,
  parameter logic [6:0] BCAST_ADDR = 7'h73,
  localparam int        WORD_W     = DATA_BYTES * BYTE_W,
  localparam int        BC_W       = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_f,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic [1:0]        phase_o,
  output logic [BC_W-1:0]   byte_cnt_o,
  output logic              ack_slot_o
);
  phase_t              phase;
  logic [3:0]          bit_cnt;
  logic                in_ack;
  logic [BYTE_W-1:0]   shreg;
  logic [BC_W-1:0]     byte_cnt;
  logic [WORD_W-1:0]   word_acc;
  logic [6:0]          own_addr;
  logic                active;
  logic                byte_done;

  assign own_addr  = strap_addr(strap_i, BASE_ADDR);
  assign active    = (phase == PH_ADDR) || (phase == PH_DATA);
  assign byte_done = scl_fall && active && !in_ack && (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      shreg     <= '0;
      byte_cnt  <= '0;
      word_acc  <= '0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_ev || stop_ev) begin
        phase    <= start_ev ? PH_ADDR : PH_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        byte_cnt <= '0;
        sda_oe   <= 1'b0;
      end else if (scl_rise && active && !in_ack && (bit_cnt < 4'd8)) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_f};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (byte_done) begin
        in_ack <= 1'b1;
        if (phase == PH_ADDR) begin
          if (addr_hit(shreg[7:1], own_addr, BCAST_ADDR) && !shreg[0]) begin
            sda_oe   <= 1'b1;
            phase    <= PH_DATA;
            byte_cnt <= '0;
          end else begin
            phase  <= PH_IGNORE;
            in_ack <= 1'b0;
          end
        end else if (byte_cnt < BC_W'(DATA_BYTES)) begin
          sda_oe   <= 1'b1;
          word_acc <= {word_acc[WORD_W-BYTE_W-1:0], shreg};
          byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == BC_W'(DATA_BYTES - 1)) begin
            cmd_valid <= 1'b1;
            cmd_word  <= {word_acc[WORD_W-BYTE_W-1:0], shreg};
          end
        end
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
      end
    end
  end

  assign phase_o    = phase;
  assign byte_cnt_o = byte_cnt;
  assign ack_slot_o = in_ack;
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         DATA_BYTES  = 3,
  parameter logic [6:0] BASE_ADDR   = 7'h10,
  parameter logic [6:0] BCAST_ADDR  = 7'h73,
  localparam int        WORD_W      = DATA_BYTES * BYTE_W,
  localparam int        BC_W        = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word
);
  logic [1:0]      raw_lines;
  logic [1:0]      filt_lines;
  logic            scl_f, sda_f;
  logic            scl_rise, scl_fall, start_ev, stop_ev;
  logic [1:0]      phase_w;
  logic [BC_W-1:0] byte_cnt_w;
  logic            ack_slot_w;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_cmd_ctrl #(
    .DATA_BYTES(DATA_BYTES),
    .BASE_ADDR (BASE_ADDR),
    .BCAST_ADDR(BCAST_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_f     (sda_f),
    .strap_i   (strap_i),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .phase_o   (phase_w),
    .byte_cnt_o(byte_cnt_w),
    .ack_slot_o(ack_slot_w)
  );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
  parameter int DATA_BYTES = 3,
  localparam int BC_W = $clog2(DATA_BYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_f,
  input logic            sda_oe,
  input logic            cmd_valid,
  input logic            ack_slot,
  input logic [1:0]      phase,
  input logic [BC_W-1:0] byte_cnt
);
  // R7
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R7
  oe_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_slot);

  // R9
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9
  valid_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (byte_cnt == BC_W'(DATA_BYTES)));

  // R5
  ignore_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == i2c_cmd_pkg::PH_IGNORE) |-> !sda_oe);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !cmd_valid));
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .sda_oe   (sda_oe),
  .cmd_valid(cmd_valid),
  .ack_slot (ack_slot_w),
  .phase    (phase_w),
  .byte_cnt (byte_cnt_w)
);

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic        sda_oe, cmd_valid;
  logic [23:0] cmd_word;
  logic        sda_bus;

  int          checks = 0;
  int          errors = 0;
  int          vcount = 0;
  logic [23:0] last_word = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_cmd_slave uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .strap_i  (strap),
    .sda_oe   (sda_oe),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      vcount = vcount + 1;
      last_word = cmd_word;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch,
                           output bit ack, output bit steady);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        repeat (3) @(negedge clk);
        scl_m = 1'b1;
        @(negedge clk);
        scl_m = 1'b0;
        repeat (Q - 4) @(negedge clk);
      end else begin
        qwait();
      end
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    s1 = sda_bus; qwait();
    s2 = sda_bus;
    scl_m = 1'b0; qwait();
    ack = !s1;
    steady = (s1 == s2);
  endtask

  function automatic logic [6:0] exp_own(input logic [1:0] s);
    exp_own = 7'h10 + ((s == 2'd0) ? 7'd0 : (s == 2'd1) ? 7'd1 : 7'd2);
  endfunction

  // Write transaction: address, then nbytes data bytes taken from w, then STOP.
  task automatic write_txn(input logic [6:0] a, input logic [23:0] w,
                           input int nbytes, input bit addr_ok, input bit glitch,
                           input string req);
    bit ack, steady;
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b0}, 1'b0, ack, steady);
    chk(ack == addr_ok, req, 32'(ack), 32'(addr_ok));
    chk(steady, "R7", 32'(steady), 1);
    for (int i = 0; i < nbytes; i++) begin
      b = (i < 3) ? w[23 - 8*i -: 8] : 8'(8'hA5 ^ i);
      send_byte(b, glitch, ack, steady);
      chk(ack == (addr_ok && i < 3), (i < 3) ? "R8" : "R10", 32'(ack),
          32'(addr_ok && i < 3));
      chk(steady, "R7", 32'(steady), 1);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit ack, steady;
    int v0;
    logic [6:0] own, other;
    logic [23:0] w;

    repeat (8) @(negedge clk);
    chk(!sda_oe && !cmd_valid, "R1", {sda_oe, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!sda_oe && !cmd_valid, "R1", {sda_oe, cmd_valid}, 0);

    // R3 R4 address sweep, strap low
    strap = 2'b00;
    for (int a = 0; a < 128; a++) begin
      bit exp;
      exp = (a == 7'h10) || (a == 7'h73);
      bus_start();
      send_byte({7'(a), 1'b0}, 1'b0, ack, steady);
      chk(ack == exp, (a == 7'h73) ? "R4" : "R3", 32'(a), 32'(exp));
      bus_stop();
    end
    chk(vcount == 0, "R11", vcount, 0);

    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      repeat (10) @(negedge clk);
      own = exp_own(2'(s));
      other = (s == 0) ? 7'h11 : (s == 1) ? 7'h12 : 7'h10;

      // R8 R9 full write to own address
      w = 24'(s * 24'h0B3A57 + 24'h5A1C03);
      v0 = vcount;
      write_txn(own, w, 3, 1'b1, 1'b0, "R3");
      chk(vcount == v0 + 1, "R9", vcount, v0 + 1);
      chk(last_word == w, "R9", last_word, w);

      // R4 R10 broadcast write with two extra bytes
      w = ~w ^ 24'(s * 24'h010203);
      v0 = vcount;
      write_txn(7'h73, w, 5, 1'b1, 1'b0, "R4");
      chk(vcount == v0 + 1, "R10", vcount, v0 + 1);
      chk(last_word == w, "R9", last_word, w);

      // R6 read to own address, then one more byte
      v0 = vcount;
      bus_start();
      send_byte({own, 1'b1}, 1'b0, ack, steady);
      chk(!ack, "R6", 32'(ack), 0);
      send_byte(8'h3C, 1'b0, ack, steady);
      chk(!ack, "R6", 32'(ack), 0);
      bus_stop();
      chk(vcount == v0, "R6", vcount, v0);

      // R5 address of another strap setting
      v0 = vcount;
      write_txn(other, 24'h123456, 3, 1'b0, 1'b0, "R5");
      chk(vcount == v0, "R5", vcount, v0);
    end

    strap = 2'b01;
    own = 7'h11;
    repeat (10) @(negedge clk);

    // R11 partial word then STOP
    v0 = vcount;
    write_txn(own, 24'hABCDEF, 2, 1'b1, 1'b0, "R11");
    chk(vcount == v0, "R11", vcount, v0);

    // R11 repeated START after one byte
    v0 = vcount;
    bus_start();
    send_byte({own, 1'b0}, 1'b0, ack, steady);
    chk(ack, "R11", 32'(ack), 1);
    send_byte(8'hEE, 1'b0, ack, steady);
    chk(ack, "R11", 32'(ack), 1);
    write_txn(own, 24'h0F1E2D, 3, 1'b1, 1'b0, "R11");
    chk(vcount == v0 + 1, "R11", vcount, v0 + 1);
    chk(last_word == 24'h0F1E2D, "R11", last_word, 24'h0F1E2D);

    // R2 byte after STOP without START
    send_byte({own, 1'b0}, 1'b0, ack, steady);
    chk(!ack, "R2", 32'(ack), 0);
    bus_stop();

    // R12 short SCL pulses inside every data byte
    v0 = vcount;
    write_txn(own, 24'h96C35A, 3, 1'b1, 1'b1, "R12");
    chk(vcount == v0 + 1, "R12", vcount, v0 + 1);
    chk(last_word == 24'h96C35A, "R12", last_word, 24'h96C35A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule